// File: doc/BRIEF.md
# Vector Memory Address Stream Generator

This block sits between the issue side of a vector unit and its memory bus. Each vector load or store arrives as a descriptor: start address, element count, byte stride, element width and access kind. The descriptor waits in a small buffer. An expansion engine then turns it into bus bursts, one per cycle at most, and places them in separate read and write request queues. Each queue drains to its own AXI-style request channel, so a stalled bus channel holds up only its own queue. Descriptor intake and expansion keep running until the queue they feed is full.

After every unit-stride load, the engine issues reads for the next interval of the same length, starting right after the end of the load, under a second bus ID. Read responses are split by ID. Demand beats go to the demand return strobe and prefetch beats go to the prefetch-buffer fill strobe. A region tag tracks the last prefetched interval. A later unit-stride load that starts at that region with the same element width and no greater length is served from the buffer once every prefetch response has returned. Such a load issues no demand read and immediately prefetches the interval after it.

The expansion engine has three states: GEN_IDLE, GEN_DEMAND and GEN_PREFETCH. GEN_IDLE pops a descriptor when one is waiting. It drops a zero-length descriptor and stays in GEN_IDLE. On a prefetch-region hit it moves to GEN_PREFETCH, and otherwise it moves to GEN_DEMAND. GEN_DEMAND emits bursts until the count runs out. It then moves to GEN_PREFETCH for a unit-stride load and back to GEN_IDLE for anything else. GEN_PREFETCH emits the look-ahead reads and returns to GEN_IDLE after the last one.

Top module: `vec_agen`

## Requirements
- R1: After reset `desc_ready` is 1 and `ar_valid`, `aw_valid` and `pf_hit` are 0.
- R2: A unit-stride access is cut into bursts of min(remaining, 16, elements left before the next 4096-byte boundary) beats. Each burst sets `*_len` to beats-1 and `*_size` to the element width code (bytes = 1 << code), and advances the address by beats << code.
- R3: A strided access issues one single-beat burst per element, with the address stepping by the byte stride.
- R4: No burst is longer than 16 beats, and no unit-stride burst crosses a 4096-byte boundary.
- R5: Loads (`desc_store`=0) issue only on the read channel with `ar_id`=0 for demand. Stores (`desc_store`=1) issue only on the write channel. Bursts leave each channel in descriptor order.
- R6: While the write channel is held not-ready with requests pending, read requests still issue.
- R7: While a bus channel is stalled, descriptors are accepted until the descriptor buffer and the queues are full.
- R8: After the demand bursts of a unit-stride load of N elements at A, the block issues reads for N elements at A + (N << width) with `ar_id`=1.
- R9: A response beat with `r_id`=0 raises only `dmd_rvalid`, and one with `r_id`=1 raises only `pf_fill_valid`.
- R10: A unit-stride load that starts at the prefetched region's start, with the same width and no greater length, after all its responses (`r_last`) have returned, pulses `pf_hit` for one cycle. It issues no demand read, and it then prefetches the next interval.
- R11: A descriptor with zero length is consumed and produces no burst.
- R12: With the read channel always ready, a strided load issues a read burst in every consecutive cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor buffer has room |
| desc_addr | input | 32 | Start byte address |
| desc_len | input | 16 | Element count |
| desc_stride | input | 32 | Byte stride (strided only) |
| desc_ew | input | 2 | Element width code, bytes = 1 << code |
| desc_store | input | 1 | 1 = store, 0 = load |
| desc_strided | input | 1 | 1 = strided, 0 = unit-stride |
| ar_valid | output | 1 | Read request valid |
| ar_ready | input | 1 | Read request accepted |
| ar_addr | output | 32 | Read burst address |
| ar_len | output | 4 | Read beats minus one |
| ar_size | output | 2 | Read beat size code |
| ar_id | output | 1 | 0 demand, 1 prefetch |
| aw_valid | output | 1 | Write request valid |
| aw_ready | input | 1 | Write request accepted |
| aw_addr | output | 32 | Write burst address |
| aw_len | output | 4 | Write beats minus one |
| aw_size | output | 2 | Write beat size code |
| r_valid | input | 1 | Read response beat |
| r_id | input | 1 | Response ID |
| r_last | input | 1 | Final beat of a burst |
| dmd_rvalid | output | 1 | Demand beat strobe |
| pf_fill_valid | output | 1 | Prefetch buffer fill strobe |
| pf_hit | output | 1 | Load served from prefetch region |

## Verification
On every cycle the assertions check:
- the burst-length and 4 KiB limits;
- the step of the remaining count;
- that look-ahead bursts are always unit-stride reads;
- that a hit goes straight to prefetching;
- queue overflow and underflow, and that read requests hold while stalled.

The bench scenarios show what only the end-to-end order can show: the exact burst sequences per channel, the next-interval prediction, and whether a hit suppresses the demand read. They also show that reads keep flowing under a blocked write channel, the one-burst-per-cycle rate, and that zero-length descriptors are dropped.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;
    localparam int ADDR_W  = 32;
    localparam int CNT_W   = 16;
    localparam int MAXBEAT = 16;
    localparam int PAGE_B  = 4096;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  len;
        logic [ADDR_W-1:0] stride;
        logic [1:0]        ew;
        logic              store;
        logic              strided;
    } vdesc_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [3:0]        len;
        logic [1:0]        size;
        logic              id;
    } burst_t;

    typedef enum logic [1:0] {
        GEN_IDLE,
        GEN_DEMAND,
        GEN_PREFETCH
    } gen_state_e;
endpackage

// File: rtl/vec_agen_fifo.sv
module vec_agen_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [PW:0]   count;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    assign dout  = mem[rptr];
    assign full  = (count == (PW+1)'(DEPTH));
    assign empty = (count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R5
endmodule

// File: rtl/vec_agen_pftag.sv
module vec_agen_pftag
    import vec_agen_pkg::*;
#(
    parameter int OUT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_base,
    input  logic [CNT_W-1:0]  arm_len,
    input  logic [1:0]        arm_ew,
    input  logic              issue,
    input  logic              issue_last,
    input  logic              rsp_valid,
    input  logic              rsp_id,
    input  logic              rsp_last,
    output logic              tag_valid,
    output logic [ADDR_W-1:0] tag_base,
    output logic [CNT_W-1:0]  tag_len,
    output logic [1:0]        tag_ew,
    output logic              dmd_valid,
    output logic              fill_valid
);
    logic             armed, issued;
    logic [OUT_W-1:0] outstanding;
    logic             pf_done;

    assign dmd_valid  = rsp_valid && !rsp_id;
    assign fill_valid = rsp_valid && rsp_id;
    assign pf_done    = fill_valid && rsp_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed       <= 1'b0;
            issued      <= 1'b0;
            tag_base    <= '0;
            tag_len     <= '0;
            tag_ew      <= '0;
            outstanding <= '0;
        end else begin
            if (arm) begin
                armed    <= 1'b1;
                issued   <= 1'b0;
                tag_base <= arm_base;
                tag_len  <= arm_len;
                tag_ew   <= arm_ew;
            end else if (issue_last) begin
                issued <= 1'b1;
            end
            outstanding <= outstanding + OUT_W'(issue) - OUT_W'(pf_done);
        end
    end

    assign tag_valid = armed && issued && (outstanding == '0);

    AST_PF_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done |-> (outstanding != '0) || issue); // R9
endmodule

// File: rtl/vec_agen_expander.sv
module vec_agen_expander
    import vec_agen_pkg::*;
#(
    parameter bit PF_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  vdesc_t            head,
    input  logic              head_valid,
    output logic              pop,
    input  logic              rd_full,
    input  logic              wr_full,
    output logic              rd_push,
    output logic              wr_push,
    output burst_t            burst,
    input  logic              tag_valid,
    input  logic [ADDR_W-1:0] tag_base,
    input  logic [CNT_W-1:0]  tag_len,
    input  logic [1:0]        tag_ew,
    output logic              arm,
    output logic [ADDR_W-1:0] arm_base,
    output logic [CNT_W-1:0]  arm_len,
    output logic              issue,
    output logic              issue_last,
    output logic              pf_hit
);
    localparam int BW = $clog2(MAXBEAT) + 1;
    localparam int PW = $clog2(PAGE_B) + 1;

    gen_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, stride_q;
    logic [CNT_W-1:0]  rem_q, len_q;
    logic [1:0]        ew_q;
    logic              store_q, strided_q;

    logic [PW-1:0]     to_bound, bound_el;
    logic [BW-1:0]     cap, beats;
    logic [ADDR_W-1:0] step, hit_next;
    logic              emit, fire, last, hit, pf_next, take;

    always_comb begin
        to_bound = PW'(PAGE_B) - {1'b0, addr_q[PW-2:0]};
        bound_el = to_bound >> ew_q;
        if (strided_q)                       cap = BW'(1);
        else if (bound_el >= PW'(MAXBEAT))   cap = BW'(MAXBEAT);
        else                                 cap = BW'(bound_el);
        beats    = (rem_q < CNT_W'(cap)) ? BW'(rem_q) : cap;
        step     = strided_q ? stride_q : (ADDR_W'(beats) << ew_q);
        emit     = (state_q != GEN_IDLE);
        fire     = emit && !(store_q ? wr_full : rd_full);
        last     = fire && (rem_q == CNT_W'(beats));
        pf_next  = PF_EN && !store_q && !strided_q;
        take     = head_valid && (head.len != '0);
        hit      = PF_EN && take && !head.store && !head.strided && tag_valid &&
                   (head.addr == tag_base) && (head.len <= tag_len) && (head.ew == tag_ew);
        hit_next = head.addr + (ADDR_W'(head.len) << head.ew);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE:     if (take) state_d = hit ? GEN_PREFETCH : GEN_DEMAND;
            GEN_DEMAND:   if (last) state_d = pf_next ? GEN_PREFETCH : GEN_IDLE;
            GEN_PREFETCH: if (last) state_d = GEN_IDLE;
            default:      state_d = GEN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pop        = (state_q == GEN_IDLE) && head_valid;
        pf_hit     = pop && hit;
        rd_push    = fire && !store_q;
        wr_push    = fire && store_q;
        burst.addr = addr_q;
        burst.len  = 4'(beats - BW'(1));
        burst.size = ew_q;
        burst.id   = (state_q == GEN_PREFETCH);
        issue      = fire && (state_q == GEN_PREFETCH);
        issue_last = issue && last;
        arm        = pf_hit || (last && (state_q == GEN_DEMAND) && pf_next);
        arm_base   = pf_hit ? hit_next : addr_q + step;
        arm_len    = pf_hit ? head.len : len_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            stride_q  <= '0;
            rem_q     <= '0;
            len_q     <= '0;
            ew_q      <= '0;
            store_q   <= 1'b0;
            strided_q <= 1'b0;
        end else if (pop && take) begin
            addr_q    <= hit ? hit_next : head.addr;
            stride_q  <= head.stride;
            rem_q     <= head.len;
            len_q     <= head.len;
            ew_q      <= head.ew;
            store_q   <= head.store && !hit;
            strided_q <= head.strided && !hit;
        end else if (fire) begin
            addr_q <= addr_q + step;
            rem_q  <= (last && (state_q == GEN_DEMAND) && pf_next) ? len_q : rem_q - CNT_W'(beats);
        end
    end

    AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (beats != '0) && (beats <= BW'(MAXBEAT))); // R4
    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !strided_q) |-> ((PW+1)'(addr_q[PW-2:0]) + ((PW+1)'(beats) << ew_q)) <= (PW+1)'(PAGE_B)); // R4
    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !last) |=> rem_q == $past(rem_q) - CNT_W'($past(beats))); // R2
    AST_PF_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_PREFETCH) |-> !store_q && !strided_q); // R8
    AST_HIT_SKIPS_DEMAND: assert property (@(posedge clk) disable iff (!rst_n)
        pf_hit |=> (state_q == GEN_PREFETCH)); // R10
endmodule

// File: rtl/vec_agen.sv
module vec_agen
    import vec_agen_pkg::*;
#(
    parameter int DESC_DEPTH = 4,
    parameter int TXN_DEPTH  = 4,
    parameter bit PF_EN      = 1'b1,
    parameter int OUT_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_valid,
    output logic        desc_ready,
    input  logic [31:0] desc_addr,
    input  logic [15:0] desc_len,
    input  logic [31:0] desc_stride,
    input  logic [1:0]  desc_ew,
    input  logic        desc_store,
    input  logic        desc_strided,
    output logic        ar_valid,
    input  logic        ar_ready,
    output logic [31:0] ar_addr,
    output logic [3:0]  ar_len,
    output logic [1:0]  ar_size,
    output logic        ar_id,
    output logic        aw_valid,
    input  logic        aw_ready,
    output logic [31:0] aw_addr,
    output logic [3:0]  aw_len,
    output logic [1:0]  aw_size,
    input  logic        r_valid,
    input  logic        r_id,
    input  logic        r_last,
    output logic        dmd_rvalid,
    output logic        pf_fill_valid,
    output logic        pf_hit
);
    localparam int DW = $bits(vdesc_t);
    localparam int TW = $bits(burst_t);

    vdesc_t d_in, d_head;
    burst_t burst, rd_head, wr_head;
    logic   d_full, d_empty, d_pop;
    logic   rd_full, rd_empty, rd_push, wr_full, wr_empty, wr_push;
    logic   arm, issue, issue_last, tag_valid;
    logic [ADDR_W-1:0] arm_base, tag_base;
    logic [CNT_W-1:0]  arm_len, tag_len;
    logic [1:0]        tag_ew;

    always_comb begin
        d_in.addr    = desc_addr;
        d_in.len     = desc_len;
        d_in.stride  = desc_stride;
        d_in.ew      = desc_ew;
        d_in.store   = desc_store;
        d_in.strided = desc_strided;
    end

    assign desc_ready = !d_full;

    vec_agen_fifo #(.W(DW), .DEPTH(DESC_DEPTH)) desc_buf_i (
        .clk(clk), .rst_n(rst_n), .push(desc_valid && !d_full), .din(d_in),
        .pop(d_pop), .dout(d_head), .full(d_full), .empty(d_empty));

    vec_agen_expander #(.PF_EN(PF_EN)) exp_i (
        .clk(clk), .rst_n(rst_n), .head(d_head), .head_valid(!d_empty), .pop(d_pop),
        .rd_full(rd_full), .wr_full(wr_full), .rd_push(rd_push), .wr_push(wr_push),
        .burst(burst), .tag_valid(tag_valid), .tag_base(tag_base), .tag_len(tag_len),
        .tag_ew(tag_ew), .arm(arm), .arm_base(arm_base), .arm_len(arm_len),
        .issue(issue), .issue_last(issue_last), .pf_hit(pf_hit));

    vec_agen_fifo #(.W(TW), .DEPTH(TXN_DEPTH)) rd_q_i (
        .clk(clk), .rst_n(rst_n), .push(rd_push), .din(burst),
        .pop(ar_valid && ar_ready), .dout(rd_head), .full(rd_full), .empty(rd_empty));

    vec_agen_fifo #(.W(TW), .DEPTH(TXN_DEPTH)) wr_q_i (
        .clk(clk), .rst_n(rst_n), .push(wr_push), .din(burst),
        .pop(aw_valid && aw_ready), .dout(wr_head), .full(wr_full), .empty(wr_empty));

    vec_agen_pftag #(.OUT_W(OUT_W)) pftag_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_base(arm_base), .arm_len(arm_len),
        .arm_ew(d_pop ? d_head.ew : burst.size), .issue(issue), .issue_last(issue_last),
        .rsp_valid(r_valid), .rsp_id(r_id), .rsp_last(r_last), .tag_valid(tag_valid),
        .tag_base(tag_base), .tag_len(tag_len), .tag_ew(tag_ew),
        .dmd_valid(dmd_rvalid), .fill_valid(pf_fill_valid));

    assign ar_valid = !rd_empty;
    assign ar_addr  = rd_head.addr;
    assign ar_len   = rd_head.len;
    assign ar_size  = rd_head.size;
    assign ar_id    = rd_head.id;
    assign aw_valid = !wr_empty;
    assign aw_addr  = wr_head.addr;
    assign aw_len   = wr_head.len;
    assign aw_size  = wr_head.size;

    AST_AR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_valid && !ar_ready) |=> ar_valid && $stable(ar_addr) && $stable(ar_len)); // R6
    AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (aw_valid && !aw_ready) |=> aw_valid && $stable(aw_addr)); // R6
endmodule

// File: tb/vec_agen_tb_top.sv
module vec_agen_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b0, desc_store = 1'b0, desc_strided = 1'b0;
    logic [31:0] desc_addr = '0, desc_stride = '0;
    logic [15:0] desc_len = '0;
    logic [1:0]  desc_ew = '0;
    logic        ar_ready = 1'b0, aw_ready = 1'b0, r_valid = 1'b0, r_id = 1'b0, r_last = 1'b0;
    logic        desc_ready, ar_valid, ar_id, aw_valid, dmd_rvalid, pf_fill_valid, pf_hit;
    logic [31:0] ar_addr, aw_addr;
    logic [3:0]  ar_len, aw_len;
    logic [1:0]  ar_size, aw_size;

    vec_agen dut_i (.*);

    int n_chk = 0, n_fail = 0;
    int ar_mode = 0, aw_mode = 0;
    int ar_cnt = 0, aw_cnt = 0, hit_cnt = 0, dmd_beats = 0, fill_beats = 0, cyc = 0;
    bit log_cyc = 1'b0, finished = 1'b0;
    logic [38:0] exp_ar[$], exp_aw[$];
    string       tag_ar[$], tag_aw[$];
    logic [1:0]  rsp_q[$];
    int          ar_cyc[$];
    bit          m_armed = 1'b0;
    logic [31:0] m_base = '0;
    logic [15:0] m_len = '0;
    logic [1:0]  m_ew = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit would_hit(logic [31:0] a, logic [15:0] n, logic [1:0] e, bit st, bit sd);
        return (n != 0) && !st && !sd && m_armed && a == m_base && n <= m_len && e == m_ew;
    endfunction

    // bursts per R2/R3/R4: min(rem,16,elements before 4 KiB) or single beat when strided
    task automatic expand(logic [31:0] a0, logic [15:0] n, logic [31:0] s, logic [1:0] e,
                          bit st, bit sd, bit id, string tg);
        logic [31:0] a = a0;
        int rem = n;
        while (rem > 0) begin
            int b, tb;
            tb = (4096 - int'(a[11:0])) >> e;
            b = sd ? 1 : ((rem < 16 ? rem : 16) < tb ? (rem < 16 ? rem : 16) : tb);
            if (st) begin exp_aw.push_back({a, 4'(b-1), e, 1'b0}); tag_aw.push_back(tg); end
            else    begin exp_ar.push_back({a, 4'(b-1), e, id});   tag_ar.push_back(tg); end
            a = a + (sd ? s : (32'(b) << e));
            rem -= b;
        end
    endtask

    task automatic model(logic [31:0] a, logic [15:0] n, logic [31:0] s, logic [1:0] e, bit st, bit sd);
        logic [31:0] nb;
        if (n == 0) return;                                   // R11
        if (!would_hit(a, n, e, st, sd))
            expand(a, n, s, e, st, sd, 1'b0, st ? "R5" : (sd ? "R3" : "R2"));
        if (!st && !sd) begin                                 // R8 / R10 next interval
            nb = a + (32'(n) << e);
            expand(nb, n, 0, e, 1'b0, 1'b0, 1'b1, "R8");
            m_armed = 1'b1; m_base = nb; m_len = n; m_ew = e;
        end
    endtask

    task automatic push_desc(logic [31:0] a, logic [15:0] n, logic [31:0] s, logic [1:0] e,
                             bit st, bit sd, output bit ok);
        int t = 0;
        while (!desc_ready && t < 60) begin @(negedge clk); t++; end
        ok = desc_ready;
        if (ok) begin
            model(a, n, s, e, st, sd);
            desc_addr = a; desc_len = n; desc_stride = s; desc_ew = e;
            desc_store = st; desc_strided = sd; desc_valid = 1'b1;
            @(negedge clk);
            desc_valid = 1'b0;
        end
    endtask

    task automatic drain();
        int t = 0;
        while ((exp_ar.size() != 0 || exp_aw.size() != 0 || rsp_q.size() != 0) && t < 3000) begin
            @(negedge clk); t++;
        end
        check(t < 3000, "R5", "drain of expected bursts", 64'(exp_ar.size() + exp_aw.size()), 0);
        repeat (4) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            ar_ready = (ar_mode == 1) ? 1'b1 : (ar_mode == 2) ? 1'b0 : ($urandom % 4 != 0);
            aw_ready = (aw_mode == 1) ? 1'b1 : (aw_mode == 2) ? 1'b0 : ($urandom % 4 != 0);
            if (ar_valid && ar_ready) begin
                logic [38:0] got;
                got = {ar_addr, ar_len, ar_size, ar_id};
                ar_cnt++;
                if (log_cyc) ar_cyc.push_back(cyc);
                if (exp_ar.size() == 0) check(1'b0, "R5", "unexpected read burst", 64'(got), 0);
                else begin
                    string tg;
                    logic [38:0] ex;
                    ex = exp_ar.pop_front();
                    tg = tag_ar.pop_front();
                    check(got == ex, tg, "read burst {addr,len,size,id}", 64'(got), 64'(ex));
                end
                for (int i = 0; i <= int'(ar_len); i++) rsp_q.push_back({ar_id, i == int'(ar_len)});
            end
            if (aw_valid && aw_ready) begin
                logic [38:0] got;
                got = {aw_addr, aw_len, aw_size, 1'b0};
                aw_cnt++;
                if (exp_aw.size() == 0) check(1'b0, "R5", "unexpected write burst", 64'(got), 0);
                else begin
                    string tg;
                    logic [38:0] ex;
                    ex = exp_aw.pop_front();
                    tg = tag_aw.pop_front();
                    check(got == ex, tg, "write burst {addr,len,size}", 64'(got), 64'(ex));
                end
            end
            if (pf_hit) hit_cnt++;
            if (rsp_q.size() != 0 && ($urandom % 2 == 0)) begin
                logic [1:0] b;
                b = rsp_q.pop_front();
                r_valid = 1'b1; r_id = b[1]; r_last = b[0];
            end else begin
                r_valid = 1'b0;
            end
            #1;
            if (r_valid) begin
                // R9: id 0 -> demand strobe only, id 1 -> fill strobe only
                check(dmd_rvalid == !r_id && pf_fill_valid == r_id, "R9", "response routing",
                      64'({dmd_rvalid, pf_fill_valid}), 64'({!r_id, r_id}));
                if (r_id) fill_beats++; else dmd_beats++;
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit ok;
        int a0, w0, h0;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(desc_ready == 1'b1, "R1", "desc_ready after reset", 64'(desc_ready), 1);
        check(!ar_valid && !aw_valid, "R1", "no request after reset", 64'({ar_valid, aw_valid}), 0);
        check(!pf_hit, "R1", "pf_hit after reset", 64'(pf_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R4: unit load crossing a 4 KiB page, then R8 next-interval prefetch
        ar_mode = 0; aw_mode = 0;
        a0 = ar_cnt;
        push_desc(32'h0000_0FC0, 16'd40, 0, 2'd2, 1'b0, 1'b0, ok);
        drain();
        check(ar_cnt - a0 == 6, "R2", "bursts for page-crossing load plus prefetch", 64'(ar_cnt - a0), 6);

        // R10: load hitting the prefetched region, only next prefetch issues
        a0 = ar_cnt; h0 = hit_cnt;
        push_desc(32'h0000_1060, 16'd40, 0, 2'd2, 1'b0, 1'b0, ok);
        drain();
        check(hit_cnt - h0 == 1, "R10", "pf_hit pulses", 64'(hit_cnt - h0), 1);
        check(ar_cnt - a0 == 3, "R10", "reads after hit (prefetch only)", 64'(ar_cnt - a0), 3);

        // R11: zero-length descriptor
        a0 = ar_cnt; w0 = aw_cnt;
        push_desc(32'h0000_8000, 16'd0, 0, 2'd0, 1'b0, 1'b0, ok);
        push_desc(32'h0000_9000, 16'd0, 0, 2'd1, 1'b1, 1'b0, ok);
        repeat (20) @(negedge clk);
        check(ar_cnt == a0 && aw_cnt == w0, "R11", "bursts from zero-length descriptors",
              64'(ar_cnt - a0 + aw_cnt - w0), 0);
        check(desc_ready, "R11", "buffer free after zero-length", 64'(desc_ready), 1);

        // R3/R12: strided load at full rate
        ar_mode = 1; ar_cyc.delete(); log_cyc = 1'b1;
        push_desc(32'h0000_2000, 16'd8, 32'h100, 2'd3, 1'b0, 1'b1, ok);
        drain();
        log_cyc = 1'b0;
        check(ar_cyc.size() == 8, "R12", "strided read burst count", 64'(ar_cyc.size()), 8);
        for (int i = 1; i < ar_cyc.size(); i++)
            check(ar_cyc[i] == ar_cyc[i-1] + 1, "R12", "cycle gap between read bursts",
                  64'(ar_cyc[i] - ar_cyc[i-1]), 1);

        // R6/R7: write channel blocked, reads and descriptor intake continue
        aw_mode = 2; ar_mode = 1;
        a0 = ar_cnt; w0 = aw_cnt;
        for (int i = 0; i < 4; i++) push_desc(32'h0000_3000 + 32'(i) * 32'h100, 16'd16, 0, 2'd2, 1'b1, 1'b0, ok);
        push_desc(32'h0000_5000, 16'd8, 0, 2'd2, 1'b0, 1'b0, ok);
        check(ok, "R7", "load accepted while writes stalled", 64'(ok), 1);
        push_desc(32'h0000_6000, 16'd4, 0, 2'd0, 1'b1, 1'b0, ok);
        check(ok, "R7", "store accepted while writes stalled", 64'(ok), 1);
        push_desc(32'h0000_6100, 16'd4, 0, 2'd0, 1'b1, 1'b0, ok);
        check(ok, "R7", "second store accepted while writes stalled", 64'(ok), 1);
        repeat (30) @(negedge clk);
        check(ar_cnt - a0 == 2, "R6", "reads issued under blocked writes", 64'(ar_cnt - a0), 2);
        check(aw_cnt == w0 && aw_valid, "R6", "write channel held", 64'(aw_cnt - w0), 0);
        aw_mode = 0; ar_mode = 0;
        drain();

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [1:0]  e;
            logic [31:0] a, s;
            logic [15:0] n;
            bit st, sd;
            e  = 2'($urandom % 4);
            st = ($urandom % 2) == 1;
            sd = ($urandom % 3) == 0;
            n  = 16'($urandom % 50);
            a  = ($urandom & 32'h000F_FFFF) & ~((32'd1 << e) - 1);
            s  = 32'(($urandom % 64) + 1) << e;
            if (would_hit(a, n, e, st, sd)) a = a ^ 32'h0010_0000;
            push_desc(a, n, s, e, st, sd, ok);
            if ($urandom % 5 == 0) drain();
        end
        drain();
        check(exp_ar.size() == 0 && exp_aw.size() == 0, "R5", "all expected bursts seen",
              64'(exp_ar.size() + exp_aw.size()), 0);
        check(dmd_beats > 0 && fill_beats > 0, "R9", "both response kinds seen",
              64'({dmd_beats != 0, fill_beats != 0}), 64'(3));
        finish_run();
    end
endmodule